// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

This block is a 32-bit interval timer that sits on a plain synchronous register bus. Software programs a start value, picks an expiry behaviour and a tick divider, and then enables the count. The count moves down by one on every qualified tick. When it runs out, the block raises a sticky interrupt flag. Depending on the mode, it then halts at zero, reloads from a stored value, or wraps to all ones. A mask bit decides whether the flag reaches the interrupt pin.

A second write port to the reload value changes only the value used at the next expiry, so a running period can be retuned without a restart. The tick input is a clock enable from elsewhere in the chip. A small divider inside the block turns it into one, sixteen or two hundred fifty-six ticks per count step. Reads are combinational from the address, and writes take effect at the clock edge.

Top module: `intv_timer`

## Requirements
- R1: After reset, the control register (offset 0x08) reads 0x20, the current count (offset 0x04) reads 0xFFFFFFFF, the raw flag is clear and `irq` is low.
- R2: A write to offset 0x00 sets both the reload value and the current count to the written data on the next edge, and restarts the tick divider.
- R3: A write to offset 0x18 changes only the reload value, which reads back at both 0x00 and 0x18. The current count is unchanged, and the next periodic expiry reloads the new value.
- R4: With control bit 7 set, the count steps once per 1, 16 or 256 `tick_en` pulses for control bits 3:2 = 00, 01 or 10; the code 11 acts as divide by 1. The divider advances only on `tick_en` while the timer is enabled.
- R5: A step taken when the effective count is 1 or 0 is an expiry, and it sets the raw flag (offset 0x10, bit 0). If an expiry and an interrupt-clear write fall in the same cycle, the flag ends set.
- R6: In periodic mode (bit 6 set, bit 0 clear), an expiry loads the count from the reload value.
- R7: In free-running mode (bits 6 and 0 clear), an expiry loads 0xFFFFFFFF when bit 1 is set and 0x0000FFFF when it is clear. With bit 1 clear, only count bits 15:0 decrement and are tested for expiry; bits 31:16 are held.
- R8: In one-shot mode (bit 0 set; this takes precedence over bit 6), an expiry sets the count to zero. A one-shot timer whose effective count is zero no longer steps and raises no further flag.
- R9: Offset 0x14 reads the raw flag ANDed with control bit 5, and `irq` is high exactly when both are set.
- R10: Any write to offset 0x0C clears the raw flag. Writes to offset 0x04 have no effect.
- R11: A control write replaces all 8 control bits at once and keeps the count, which then continues under the new settings. It also clears the tick divider. While bit 7 is clear, the count holds its value.
- R12: Reads of 0x0C and of any offset other than 0x00 to 0x18 return zero, and writes there change nothing. Bits 1:0 of the address are ignored.
- R13: A write to 0x00 or 0x08 suppresses any count step in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Count tick qualifier |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq | output | 1 | Masked interrupt |

## Verification
The bench targets the expiry edge cases. In 16-bit mode it preloads the upper half with a nonzero value: a design that decremented the whole word, or tested all 32 bits for zero, would borrow into bits 31:16 and miss the expiry. It aligns an interrupt clear with the expiry cycle, where a design with clear-over-set priority would lose the interrupt. It runs a one-shot timer loaded with zero, where a design without the halt would wrap and interrupt. It also runs the dividers on a gapped tick stream and rewrites control in mid-count. A divider that counted clocks instead of ticks, or that kept its phase across a write, would step the count early.

// File: rtl/intv_timer_pkg.sv
// Package: shared constants and types for the interval timer.
// Assumes a 32-bit data path and word-aligned register offsets.
package intv_timer_pkg;

    localparam int DATA_W      = 32;
    localparam int HALF_W      = 16;
    localparam int DIV16_BITS  = 4;
    localparam int DIV256_BITS = 8;
    localparam int PRESC_W     = DIV256_BITS;
    localparam int NUM_REGS    = 7;

    localparam logic [7:0] CTRL_RST = 8'h20;

    // Control byte, most significant bit first.
    typedef struct packed {
        logic       enable;    // bit 7
        logic       periodic;  // bit 6
        logic       irq_en;    // bit 5
        logic       spare;     // bit 4, stored only
        logic [1:0] div_sel;   // bits 3:2
        logic       wide;      // bit 1
        logic       oneshot;   // bit 0
    } tmr_ctrl_t;

    // Word index of each register; the order fixes the offsets.
    typedef enum logic [2:0] {
        SEL_LOAD  = 3'd0,
        SEL_VALUE = 3'd1,
        SEL_CTRL  = 3'd2,
        SEL_ICLR  = 3'd3,
        SEL_RAW   = 3'd4,
        SEL_MASK  = 3'd5,
        SEL_BGLD  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

endpackage

// File: rtl/intv_timer_prescale.sv
// Tick divider: counts qualified ticks and emits a one-cycle step every
// 1, 16 or 256 of them. Assumes clr comes from a load or control write;
// clr restarts the phase and blocks a step in the same cycle.
module intv_timer_prescale
    import intv_timer_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       clr,
    input  logic [1:0] div_sel,
    output logic       step
);

    logic [PRESC_W-1:0] presc_q;
    logic               hit;

    // Purpose: advance the divider on enabled ticks, restart it on clr.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presc_q <= '0;
        end else if (clr) begin
            presc_q <= '0;
        end else if (tick && run) begin
            presc_q <= presc_q + 1'b1;
        end
    end

    // Purpose: terminal-count match for the selected ratio.
    always_comb begin
        unique case (div_sel)
            2'b01:   hit = (presc_q[DIV16_BITS-1:0] == '1);
            2'b10:   hit = (presc_q[DIV256_BITS-1:0] == '1);
            default: hit = 1'b1;
        endcase
    end

    assign step = tick && run && !clr && hit;

endmodule

// File: rtl/intv_timer_counter.sv
// Main down-counter: handles load, decrement and the three expiry
// behaviours. Assumes step is already gated by enable and by bus writes.
module intv_timer_counter
    import intv_timer_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              step,
    input  tmr_ctrl_t         ctrl,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] count_q,
    output logic              expire
);

    localparam logic [DATA_W-1:0] WRAP_WIDE = '1;
    localparam logic [DATA_W-1:0] WRAP_HALF = {{(DATA_W-HALF_W){1'b0}}, {HALF_W{1'b1}}};

    logic              eff_zero;
    logic              eff_one;
    logic              halted;
    logic [DATA_W-1:0] dec_val;
    logic [DATA_W-1:0] wrap_val;
    logic [HALF_W-1:0] low_dec;

    // Purpose: effective-width zero/one detection and decrement value.
    always_comb begin
        low_dec = count_q[HALF_W-1:0] - 1'b1;
        if (ctrl.wide) begin
            eff_zero = (count_q == '0);
            eff_one  = (count_q == DATA_W'(1));
            dec_val  = count_q - 1'b1;
            wrap_val = WRAP_WIDE;
        end else begin
            eff_zero = (count_q[HALF_W-1:0] == '0);
            eff_one  = (count_q[HALF_W-1:0] == HALF_W'(1));
            dec_val  = {count_q[DATA_W-1:HALF_W], low_dec};
            wrap_val = WRAP_HALF;
        end
    end

    assign halted = ctrl.oneshot && eff_zero;
    assign expire = step && !halted && (eff_zero || eff_one);

    // Purpose: update the count from a load, an expiry or a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '1;
        end else if (load_wr) begin
            count_q <= wdata;
        end else if (expire) begin
            if (ctrl.oneshot)       count_q <= '0;
            else if (ctrl.periodic) count_q <= reload;
            else                    count_q <= wrap_val;
        end else if (step && !halted) begin
            count_q <= dec_val;
        end
    end

endmodule

// File: rtl/intv_timer_regs.sv
// Register file: address decode, control and reload storage, raw flag,
// read mux. Assumes a single-cycle write strobe; reads are combinational.
module intv_timer_regs
    import intv_timer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [DATA_W-1:0] count_q,
    input  logic              expire,
    output tmr_ctrl_t         ctrl_q,
    output logic [DATA_W-1:0] reload_q,
    output logic              raw_q,
    output logic              load_wr,
    output logic              ctrl_wr,
    output logic [DATA_W-1:0] bus_rdata
);

    localparam int WORD_W = ADDR_W - 2;

    logic [WORD_W-1:0] word_idx;
    reg_sel_e          sel;
    logic              bg_wr;
    logic              clr_wr;

    // Purpose: map the word index onto a register select.
    always_comb begin
        word_idx = bus_addr[ADDR_W-1:2];
        if (word_idx < WORD_W'(NUM_REGS)) sel = reg_sel_e'(word_idx[2:0]);
        else                              sel = SEL_NONE;
    end

    assign load_wr = bus_we && (sel == SEL_LOAD);
    assign ctrl_wr = bus_we && (sel == SEL_CTRL);
    assign bg_wr   = bus_we && (sel == SEL_BGLD);
    assign clr_wr  = bus_we && (sel == SEL_ICLR);

    // Purpose: control register storage.
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= tmr_ctrl_t'(CTRL_RST);
        else if (ctrl_wr) ctrl_q <= tmr_ctrl_t'(bus_wdata[7:0]);
    end

    // Purpose: reload value, written by both load ports.
    always_ff @(posedge clk) begin
        if (!rst_n)                reload_q <= '0;
        else if (load_wr || bg_wr) reload_q <= bus_wdata;
    end

    // Purpose: sticky raw flag; an expiry wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n)      raw_q <= 1'b0;
        else if (expire) raw_q <= 1'b1;
        else if (clr_wr) raw_q <= 1'b0;
    end

    // Purpose: read data for the addressed register.
    always_comb begin
        bus_rdata = '0;
        unique case (sel)
            SEL_LOAD, SEL_BGLD: bus_rdata = reload_q;
            SEL_VALUE:          bus_rdata = count_q;
            SEL_CTRL:           bus_rdata = {{(DATA_W-8){1'b0}}, ctrl_q};
            SEL_RAW:            bus_rdata = {{(DATA_W-1){1'b0}}, raw_q};
            SEL_MASK:           bus_rdata = {{(DATA_W-1){1'b0}}, raw_q && ctrl_q.irq_en};
            default:            bus_rdata = '0;
        endcase
    end

endmodule

// File: rtl/intv_timer.sv
// Top of the interval timer: ties together the register file, the tick
// divider and the down-counter. Assumes tick_en is synchronous to clk.
module intv_timer
    import intv_timer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);

    tmr_ctrl_t         ctrl_q;
    logic [DATA_W-1:0] reload_q;
    logic [DATA_W-1:0] count_q;
    logic              raw_q;
    logic              load_wr;
    logic              ctrl_wr;
    logic              step;
    logic              expire;

    intv_timer_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .count_q   (count_q),
        .expire    (expire),
        .ctrl_q    (ctrl_q),
        .reload_q  (reload_q),
        .raw_q     (raw_q),
        .load_wr   (load_wr),
        .ctrl_wr   (ctrl_wr),
        .bus_rdata (bus_rdata)
    );

    intv_timer_prescale u_presc (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick_en),
        .run     (ctrl_q.enable),
        .clr     (load_wr || ctrl_wr),
        .div_sel (ctrl_q.div_sel),
        .step    (step)
    );

    intv_timer_counter u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_wr (load_wr),
        .wdata   (bus_wdata),
        .step    (step),
        .ctrl    (ctrl_q),
        .reload  (reload_q),
        .count_q (count_q),
        .expire  (expire)
    );

    assign irq = raw_q && ctrl_q.irq_en;

endmodule

// File: rtl/intv_timer_chk.sv
// Checker: temporal properties of the interval timer, bound to the top.
module intv_timer_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_we,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              irq,
    input logic [7:0]        ctrl_bits,
    input logic [31:0]       count_q,
    input logic              raw_q,
    input logic              step,
    input logic              expire
);

    localparam logic [ADDR_W-1:0] A_LOAD = ADDR_W'('h00);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'('h08);
    localparam logic [ADDR_W-1:0] A_ICLR = ADDR_W'('h0C);
    localparam logic [ADDR_W-1:0] A_MASK = ADDR_W'('h14);
    localparam logic [ADDR_W-1:0] A_BGLD = ADDR_W'('h18);

    p_load_sets_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_LOAD) |=> (count_q == $past(bus_wdata)));

    p_bg_keeps_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_BGLD && !step) |=> $stable(count_q));

    p_expiry_sets_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> raw_q);

    p_oneshot_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && ctrl_bits[0]) |=> (count_q == 32'd0));

    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_bits[5] |-> !irq);

    p_masked_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == A_MASK && irq) |-> (bus_rdata == 32'd1));

    p_clear_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == A_ICLR && !expire) |=> !raw_q);

    p_frozen_when_off_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_bits[7] && !(bus_we && bus_addr == A_LOAD)) |=> $stable(count_q));

    p_no_step_on_write_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && (bus_addr == A_LOAD || bus_addr == A_CTRL)) |-> !step);

endmodule

bind intv_timer intv_timer_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq),
    .ctrl_bits (ctrl_q),
    .count_q   (count_q),
    .raw_q     (raw_q),
    .step      (step),
    .expire    (expire)
);

// File: tb/intv_timer_tb_top.sv
// Bench: behavioural reference model stepped alongside the design and
// compared on every clock.
module intv_timer_tb_top;

    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_en = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic          bus_we = 1'b0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic          irq;

    int checks = 0;
    int failures = 0;
    string tag = "R1";

    // Reference model state.
    logic [31:0] m_count;
    logic [31:0] m_reload;
    logic [7:0]  m_ctrl;
    bit          m_raw;
    int          m_ticks;

    always #5 clk = ~clk;

    intv_timer #(.ADDR_W(AW)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_en   (tick_en),
        .bus_addr  (bus_addr),
        .bus_we    (bus_we),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s act=0x%08h exp=0x%08h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] model_read(input logic [AW-1:0] a);
        case (a[AW-1:2])
            10'd0, 10'd6: return m_reload;
            10'd1:        return m_count;
            10'd2:        return {24'd0, m_ctrl};
            10'd4:        return {31'd0, m_raw};
            10'd5:        return {31'd0, m_raw & m_ctrl[5]};
            default:      return 32'd0;
        endcase
    endfunction

    task automatic model_reset();
        m_count = 32'hFFFF_FFFF;
        m_reload = 32'd0;
        m_ctrl = 8'h20;
        m_raw = 1'b0;
        m_ticks = 0;
    endtask

    task automatic model_step(input logic we, input logic [AW-1:0] a,
                              input logic [31:0] d, input logic tk);
        logic wr_load, wr_ctrl, wr_bg, wr_clr, step, exp;
        logic [31:0] eff, nc;
        int w;
        w = int'(a[AW-1:2]);
        wr_load = we && w == 0;
        wr_ctrl = we && w == 2;
        wr_bg   = we && w == 6;
        wr_clr  = we && w == 3;
        step = 1'b0;
        exp = 1'b0;
        if (wr_load || wr_ctrl) begin
            m_ticks = 0;
        end else if (tk && m_ctrl[7]) begin
            m_ticks = (m_ticks + 1) % 256;
            case (m_ctrl[3:2])
                2'b01:   step = (m_ticks % 16 == 0);
                2'b10:   step = (m_ticks == 0);
                default: step = 1'b1;
            endcase
        end
        eff = m_ctrl[1] ? m_count : (m_count & 32'h0000_FFFF);
        nc = m_count;
        if (wr_load) begin
            nc = d;
        end else if (step && !(m_ctrl[0] && eff == 0)) begin
            if (eff <= 1) begin
                exp = 1'b1;
                if (m_ctrl[0])      nc = 32'd0;
                else if (m_ctrl[6]) nc = m_reload;
                else                nc = m_ctrl[1] ? 32'hFFFF_FFFF : 32'h0000_FFFF;
            end else if (m_ctrl[1]) begin
                nc = m_count - 1;
            end else begin
                nc = (m_count & 32'hFFFF_0000) | ((eff - 1) & 32'h0000_FFFF);
            end
        end
        if (wr_load || wr_bg) m_reload = d;
        if (wr_ctrl) m_ctrl = d[7:0];
        if (exp) m_raw = 1'b1;
        else if (wr_clr) m_raw = 1'b0;
        m_count = nc;
    endtask

    // One bus cycle: drive, compare, then advance the model at the edge.
    task automatic cyc(input logic we, input logic [AW-1:0] a,
                       input logic [31:0] d, input logic tk);
        @(negedge clk);
        bus_we = we;
        bus_addr = a;
        bus_wdata = d;
        tick_en = tk;
        #1;
        check({tag, " rdata"}, bus_rdata, model_read(a));
        check({tag, " irq"}, {31'd0, irq}, {31'd0, m_raw & m_ctrl[5]});
        @(posedge clk);
        if (rst_n) model_step(we, a, d, tk);
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
        cyc(1'b1, a, d, 1'b1);
    endtask

    task automatic run(input int n, input logic [AW-1:0] a, input int gap);
        for (int i = 0; i < n; i++) cyc(1'b0, a, 32'd0, (gap == 0) || (i % gap == 0));
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values.
        tag = "R1";
        cyc(1'b0, 12'h008, 0, 1'b0);
        check("R1 ctrl reset", bus_rdata, 32'h20);
        cyc(1'b0, 12'h004, 0, 1'b0);
        check("R1 count reset", bus_rdata, 32'hFFFF_FFFF);
        cyc(1'b0, 12'h010, 0, 1'b0);

        // R2 with the timer off, R11 freeze.
        tag = "R2";
        wr(12'h000, 32'd5);
        cyc(1'b0, 12'h004, 0, 1'b1);
        check("R2 count loaded", bus_rdata, 32'd5);
        tag = "R11";
        run(8, 12'h004, 0);

        // R6 periodic divide-by-1, R9 irq, R10 clear.
        tag = "R6";
        wr(12'h008, 32'hE0);
        run(14, 12'h004, 0);
        tag = "R9";
        run(2, 12'h014, 0);
        tag = "R10";
        wr(12'h00C, 32'd0);
        run(2, 12'h010, 0);

        // R3 background load while running.
        tag = "R3";
        wr(12'h018, 32'd2);
        run(3, 12'h000, 0);
        run(10, 12'h004, 0);

        // R4 dividers on a gapped tick stream.
        tag = "R4";
        wr(12'h008, 32'hE4);
        wr(12'h000, 32'd3);
        run(140, 12'h004, 2);
        wr(12'h008, 32'hE8);
        wr(12'h000, 32'd1);
        run(600, 12'h004, 0);
        wr(12'h008, 32'hEC);
        run(12, 12'h004, 0);

        // R5 expiry and clear in the same cycle: the flag stays set.
        tag = "R5";
        wr(12'h00C, 32'd0);
        wr(12'h008, 32'hE0);
        wr(12'h000, 32'd3);
        while (m_count != 32'd1) cyc(1'b0, 12'h010, 0, 1'b1);
        wr(12'h00C, 32'd0);
        cyc(1'b0, 12'h010, 0, 1'b0);
        check("R5 set beats clear", bus_rdata, 32'd1);

        // R7 free-running, 16-bit with upper half held, then 32-bit.
        tag = "R7";
        wr(12'h00C, 32'd0);
        wr(12'h008, 32'hA0);
        wr(12'h000, 32'h0003_0002);
        run(6, 12'h004, 0);
        wr(12'h008, 32'hA2);
        wr(12'h000, 32'd2);
        run(5, 12'h004, 0);

        // R8 one-shot wins over periodic; zero-loaded one-shot stays idle.
        tag = "R8";
        wr(12'h008, 32'hE1);
        wr(12'h000, 32'd3);
        run(10, 12'h004, 0);
        wr(12'h00C, 32'd0);
        wr(12'h000, 32'd0);
        run(6, 12'h010, 0);
        cyc(1'b0, 12'h010, 0, 1'b0);
        check("R8 no flag from idle one-shot", bus_rdata, 32'd0);

        // R9 masked off: raw set, masked view and irq low.
        tag = "R9";
        wr(12'h008, 32'hC0);
        wr(12'h000, 32'd2);
        run(5, 12'h010, 0);
        run(3, 12'h014, 0);
        wr(12'h008, 32'hE0);
        run(2, 12'h014, 0);

        // R10 write to the value register is ignored.
        tag = "R10";
        wr(12'h008, 32'h60);
        wr(12'h004, 32'h1234);
        run(2, 12'h004, 0);

        // R11 control rewrite keeps the count, then disable freezes it.
        tag = "R11";
        wr(12'h008, 32'hE0);
        wr(12'h000, 32'd100);
        run(5, 12'h004, 0);
        wr(12'h008, 32'hE4);
        run(20, 12'h004, 0);
        wr(12'h008, 32'h60);
        run(10, 12'h004, 0);

        // R12 undefined offsets and ignored low address bits.
        tag = "R12";
        run(2, 12'h00C, 0);
        run(2, 12'h01C, 0);
        run(2, 12'h100, 0);
        wr(12'h01C, 32'hFFFF_FFFF);
        wr(12'h200, 32'hFFFF_FFFF);
        run(2, 12'h002, 0);
        run(2, 12'h00B, 0);

        // R13 back-to-back load and control writes block stepping.
        tag = "R13";
        wr(12'h008, 32'hE0);
        wr(12'h000, 32'd9);
        for (int i = 0; i < 6; i++) wr(12'h008, 32'hE0);
        cyc(1'b0, 12'h004, 0, 1'b0);
        check("R13 no step during writes", bus_rdata, 32'd9);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule